// File: doc/BRIEF.md
# Three-Trit Ternary Wallace Multiplier

This block multiplies two unsigned ternary numbers of three digits each and returns their six-digit product. Every ternary digit (trit) travels on two binary wires. The datapath has three parts. A three-by-three array of single-digit multiplier cells forms a product digit and a carry digit for each pair of operand digits. A Wallace-style tree then cuts each column down to at most two entries. A short ripple stage finishes the sum.

The tree relies on one arithmetic fact: a digit product never exceeds four, so every carry out of a digit cell is 0 or 1. Because of this, the tree uses no general three-input ternary adders. It uses half adders and two narrower full adders. One narrow adder takes two full-range digits and one binary-range digit. The other takes one full-range digit and two binary-range digits.

Every digit cell picks its output with a three-way selector driven by one ternary select digit. An operand digit that carries the unused code raises an error flag. The result is registered behind a parameter-selected output stage.

Top module: `ternary_wallace_mul3`

## Requirements
- R1: A digit is coded 2'b00 = 0, 2'b01 = 1, 2'b10 = 2. Digit k of an operand or of the product sits on bits [2k+1:2k], with weight 3^k.
- R2: Each single-digit cell returns product digit (a·b mod 3) and carry digit (a·b div 3), and the carry is never 2.
- R3: For every pair of legal operands (0..26 each), the product output equals the integer product, coded as in R1.
- R4: The six product digits always hold legal codes. The largest result, 26·26 = 676, fits without any carry left over past the top digit.
- R5: In the first narrow full adder, the third operand is always 0 or 1.
- R6: In the second narrow full adder, the second and third operands are always 0 or 1.
- R7: Every adder cell returns sum = total mod 3 and carry = total div 3.
- R8: err_o is 1 in the same output cycle as a product whose operands hold any digit coded 2'b11. Such a digit counts as 0 in that product.
- R9: With the default registered output, a new operand pair shows on prod_o and err_o one rising clock edge after it is applied, and the old value holds until that edge. Reset clears prod_o and err_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 6 | Multiplicand, three coded digits |
| b_i | input | 6 | Multiplier, three coded digits |
| prod_o | output | 12 | Product, six coded digits |
| err_o | output | 1 | Illegal digit code seen on an operand |

## Verification
The error flag and the product land in the same output register at the same edge. The bench therefore applies operands that mix illegal digits with legal ones, on the multiplicand side and on the multiplier side. In that one cycle it checks both that err_o is 1 and that prod_o equals the product computed with the illegal digits taken as 0. A following legal pair must clear the flag while the product updates at the same edge. An exhaustive sweep over all 729 legal pairs, together with the range and value assertions inside each adder, shows that the narrow adders only ever receive 0 or 1 on their binary-range inputs.

// File: rtl/ternary_pkg.sv
package ternary_pkg;

   typedef logic [1:0] trit_t;

   localparam trit_t T0 = 2'b00;
   localparam trit_t T1 = 2'b01;
   localparam trit_t T2 = 2'b10;

   typedef enum logic [1:0] {
      ADD_HALF = 2'd0,
      ADD_PPC  = 2'd1,
      ADD_PCC  = 2'd2
   } add_kind_e;

   function automatic trit_t t_inc(trit_t x);
      case (x)
         T0:      return T1;
         T1:      return T2;
         T2:      return T0;
         default: return T1;
      endcase
   endfunction

   function automatic trit_t t_dbl(trit_t x);
      case (x)
         T1:      return T2;
         T2:      return T1;
         default: return T0;
      endcase
   endfunction

   function automatic logic t_legal(trit_t x);
      return x != 2'b11;
   endfunction

   function automatic int t_val(trit_t x);
      return int'(x);
   endfunction

endpackage

// File: rtl/ternary_mux3.sv
module ternary_mux3
   import ternary_pkg::*;
(
   input  trit_t sel,
   input  trit_t d0,
   input  trit_t d1,
   input  trit_t d2,
   output trit_t y
);

   always_comb begin
      case (sel)
         T0:      y = d0;
         T1:      y = d1;
         T2:      y = d2;
         default: y = T0;
      endcase
   end

endmodule

// File: rtl/ternary_digit_mul.sv
module ternary_digit_mul
   import ternary_pkg::*;
(
   input  trit_t a,
   input  trit_t b,
   output trit_t p,
   output trit_t c
);

   trit_t a_s;
   trit_t a_dbl;
   trit_t a_hi;

   assign a_s   = t_legal(a) ? a : T0;
   assign a_dbl = t_dbl(a_s);
   assign a_hi  = (a_s == T2) ? T1 : T0;

   ternary_mux3 u_prod (.sel(b), .d0(T0), .d1(a_s), .d2(a_dbl), .y(p));
   ternary_mux3 u_cry  (.sel(b), .d0(T0), .d1(T0),  .d2(a_hi),  .y(c));

   always_comb begin
      a_r2_digit_value: assert (!t_legal(a) || !t_legal(b) ||
                                (3 * t_val(c) + t_val(p) == t_val(a) * t_val(b)))
         else $error("digit cell value mismatch");
      a_r2_carry_binary: assert (c == T0 || c == T1)
         else $error("digit cell carry out of range");
   end

endmodule

// File: rtl/ternary_add.sv
module ternary_add
   import ternary_pkg::*;
#(
   parameter add_kind_e KIND = ADD_HALF
)(
   input  trit_t x,
   input  trit_t y,
   input  trit_t z,
   output trit_t s,
   output trit_t co
);

   if (KIND == ADD_HALF) begin : g_half
      trit_t x1, x2, cy1, cy2;
      assign x1  = t_inc(x);
      assign x2  = t_inc(x1);
      assign cy1 = (x == T2) ? T1 : T0;
      assign cy2 = (x == T0) ? T0 : T1;
      ternary_mux3 u_sum (.sel(y), .d0(x),  .d1(x1),  .d2(x2),  .y(s));
      ternary_mux3 u_cry (.sel(y), .d0(T0), .d1(cy1), .d2(cy2), .y(co));
      always_comb begin
         a_r7_half_third_idle: assert (z == T0)
            else $error("half adder third input not tied to zero");
      end
   end else if (KIND == ADD_PPC) begin : g_ppc
      trit_t x1, x2, cy1, cy2, s1, c1, s1i, c1z;
      assign x1  = t_inc(x);
      assign x2  = t_inc(x1);
      assign cy1 = (x == T2) ? T1 : T0;
      assign cy2 = (x == T0) ? T0 : T1;
      ternary_mux3 u_sum1 (.sel(y), .d0(x),  .d1(x1),  .d2(x2),  .y(s1));
      ternary_mux3 u_cry1 (.sel(y), .d0(T0), .d1(cy1), .d2(cy2), .y(c1));
      assign s1i = t_inc(s1);
      assign c1z = (s1 == T2) ? T1 : c1;
      ternary_mux3 u_sum2 (.sel(z), .d0(s1), .d1(s1i), .d2(s1), .y(s));
      ternary_mux3 u_cry2 (.sel(z), .d0(c1), .d1(c1z), .d2(c1), .y(co));
      always_comb begin
         a_r5_ppc_third_binary: assert (z == T0 || z == T1)
            else $error("first narrow adder: third input above one");
      end
   end else begin : g_pcc
      trit_t xi, xc, u, cu, ui, cuy;
      assign xi = t_inc(x);
      assign xc = (x == T2) ? T1 : T0;
      ternary_mux3 u_sum1 (.sel(z), .d0(x),  .d1(xi), .d2(x),  .y(u));
      ternary_mux3 u_cry1 (.sel(z), .d0(T0), .d1(xc), .d2(T0), .y(cu));
      assign ui  = t_inc(u);
      assign cuy = (u == T2) ? T1 : cu;
      ternary_mux3 u_sum2 (.sel(y), .d0(u),  .d1(ui),  .d2(u),  .y(s));
      ternary_mux3 u_cry2 (.sel(y), .d0(cu), .d1(cuy), .d2(cu), .y(co));
      always_comb begin
         a_r6_pcc_y_binary: assert (y == T0 || y == T1)
            else $error("second narrow adder: second input above one");
         a_r6_pcc_z_binary: assert (z == T0 || z == T1)
            else $error("second narrow adder: third input above one");
      end
   end

   always_comb begin
      a_r7_sum_value: assert (3 * t_val(co) + t_val(s) == t_val(x) + t_val(y) + t_val(z))
         else $error("adder cell sum/carry mismatch");
      a_r7_carry_binary: assert (co == T0 || co == T1)
         else $error("adder cell carry above one");
   end

endmodule

// File: rtl/ternary_wallace_mul3.sv
module ternary_wallace_mul3
   import ternary_pkg::*;
#(
   parameter int N_TRITS = 3,
   parameter int TW      = 2,
   parameter bit REG_OUT = 1'b1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_TRITS*TW-1:0]        a_i,
   input  logic [N_TRITS*TW-1:0]        b_i,
   output logic [2*N_TRITS*TW-1:0]      prod_o,
   output logic                         err_o
);

   localparam int OPW = N_TRITS * TW;
   localparam int RW  = 2 * OPW;
   localparam int RT  = 2 * N_TRITS;

   if (N_TRITS != 3) begin : g_bad_width
      $error("tree netlist is laid out for three-digit operands");
   end
   if (TW != 2) begin : g_bad_code
      $error("digit code must be two bits wide");
   end

   trit_t pt [N_TRITS][N_TRITS];
   trit_t ct [N_TRITS][N_TRITS];
   logic [N_TRITS-1:0] bad_a, bad_b;

   for (genvar i = 0; i < N_TRITS; i++) begin : g_row
      assign bad_a[i] = !t_legal(a_i[TW*i +: TW]);
      assign bad_b[i] = !t_legal(b_i[TW*i +: TW]);
      for (genvar j = 0; j < N_TRITS; j++) begin : g_col
         ternary_digit_mul u_dm (
            .a(a_i[TW*i +: TW]), .b(b_i[TW*j +: TW]),
            .p(pt[i][j]), .c(ct[i][j])
         );
      end
   end

   // stage 1
   trit_t s1c1, k1, s2a, k2, s3a, k3, s4a, k4;
   ternary_add #(.KIND(ADD_PPC)) u_s1c1 (.x(pt[0][1]), .y(pt[1][0]), .z(ct[0][0]), .s(s1c1), .co(k1));
   ternary_add #(.KIND(ADD_PPC)) u_s1c2 (.x(pt[0][2]), .y(pt[1][1]), .z(ct[0][1]), .s(s2a),  .co(k2));
   ternary_add #(.KIND(ADD_PCC)) u_s1c3 (.x(pt[1][2]), .y(ct[0][2]), .z(ct[1][1]), .s(s3a),  .co(k3));
   ternary_add #(.KIND(ADD_PCC)) u_s1c4 (.x(pt[2][2]), .y(ct[1][2]), .z(ct[2][1]), .s(s4a),  .co(k4));

   // stage 2
   trit_t x2, m2, x3, m3;
   ternary_add #(.KIND(ADD_PPC)) u_s2c2 (.x(s2a), .y(pt[2][0]), .z(ct[1][0]), .s(x2), .co(m2));
   ternary_add #(.KIND(ADD_PPC)) u_s2c3 (.x(s3a), .y(pt[2][1]), .z(ct[2][0]), .s(x3), .co(m3));

   // stage 3
   trit_t y3, n3, y4, n4, y5, n5;
   ternary_add #(.KIND(ADD_PCC)) u_s3c3 (.x(x3),       .y(k2), .z(m2), .s(y3), .co(n3));
   ternary_add #(.KIND(ADD_PCC)) u_s3c4 (.x(s4a),      .y(k3), .z(m3), .s(y4), .co(n4));
   ternary_add #(.KIND(ADD_PCC)) u_s3c5 (.x(ct[2][2]), .y(k4), .z(n4), .s(y5), .co(n5));

   // carry-propagate stage
   trit_t r2, q2, r3, q3, r4, q4, r5, q5;
   ternary_add #(.KIND(ADD_HALF)) u_cp2 (.x(x2), .y(k1), .z(T0), .s(r2), .co(q2));
   ternary_add #(.KIND(ADD_HALF)) u_cp3 (.x(y3), .y(q2), .z(T0), .s(r3), .co(q3));
   ternary_add #(.KIND(ADD_PCC))  u_cp4 (.x(y4), .y(n3), .z(q3), .s(r4), .co(q4));
   ternary_add #(.KIND(ADD_HALF)) u_cp5 (.x(y5), .y(q4), .z(T0), .s(r5), .co(q5));

   logic [RW-1:0] prod_c;
   logic          err_c;

   assign prod_c = {r5, r4, r3, r2, s1c1, pt[0][0]};
   assign err_c  = |{bad_a, bad_b};

   always_comb begin
      a_r4_no_spill: assert (n5 == T0 && q5 == T0)
         else $error("carry left past the top product digit");
      for (int k = 0; k < RT; k++) begin
         a_r4_digit_legal: assert (t_legal(prod_c[TW*k +: TW]))
            else $error("illegal code on product digit");
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_o <= '0;
            err_o  <= 1'b0;
         end else begin
            prod_o <= prod_c;
            err_o  <= err_c;
         end
      end
   end else begin : g_comb
      assign prod_o = prod_c;
      assign err_o  = err_c;
   end

endmodule

// File: tb/sim_ternary_wallace_mul3.sv
module sim_ternary_wallace_mul3;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  a_i = '0;
   logic [5:0]  b_i = '0;
   logic [11:0] prod_o;
   logic        err_o;

   int checks = 0;
   int failures = 0;

   always #(CLK_P/2) clk = ~clk;

   ternary_wallace_mul3 u0 (
      .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
      .prod_o(prod_o), .err_o(err_o)
   );

   function automatic logic [5:0] enc3(int v);
      logic [5:0] r;
      int t = v;
      for (int k = 0; k < 3; k++) begin
         r[2*k +: 2] = 2'(t % 3);
         t = t / 3;
      end
      return r;
   endfunction

   function automatic logic [11:0] enc6(int v);
      logic [11:0] r;
      int t = v;
      for (int k = 0; k < 6; k++) begin
         r[2*k +: 2] = 2'(t % 3);
         t = t / 3;
      end
      return r;
   endfunction

   // illegal digits count as zero
   function automatic int dec3_zero(logic [5:0] x);
      int acc = 0;
      int w = 1;
      for (int k = 0; k < 3; k++) begin
         if (x[2*k +: 2] != 2'b11) acc += int'(x[2*k +: 2]) * w;
         w *= 3;
      end
      return acc;
   endfunction

   function automatic int dec6(logic [11:0] x);
      int acc = 0;
      int w = 1;
      for (int k = 0; k < 6; k++) begin
         if (x[2*k +: 2] == 2'b11) return -1;
         acc += int'(x[2*k +: 2]) * w;
         w *= 3;
      end
      return acc;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (a=%b b=%b)", req, act, exp, a_i, b_i);
      end
   endtask

   task automatic apply(logic [5:0] a, logic [5:0] b);
      @(negedge clk);
      a_i = a;
      b_i = b;
      @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      chk("R9 reset prod", int'(prod_o), 0);
      chk("R9 reset err", int'(err_o), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_single_digit();
      apply(enc3(2), enc3(2));
      chk("R2 2x2 raw code", int'(prod_o), int'(12'b0000_0000_0101));
      apply(enc3(1), enc3(2));
      chk("R1 1x2 raw code", int'(prod_o), int'(12'b0000_0000_0010));
      apply(enc3(9), enc3(2));
      chk("R1 digit position", int'(prod_o), int'(12'b0000_0010_0000));
   endtask

   task automatic t_exhaustive();
      for (int ia = 0; ia < 27; ia++) begin
         for (int ib = 0; ib < 27; ib++) begin
            apply(enc3(ia), enc3(ib));
            chk("R3 R5 R6 R7 product", dec6(prod_o), ia * ib);
            chk("R8 err low on legal", int'(err_o), 0);
         end
      end
   endtask

   task automatic t_max();
      apply(enc3(26), enc3(26));
      chk("R4 max raw", int'(prod_o), int'(enc6(676)));
      chk("R4 max value", dec6(prod_o), 676);
      apply(enc3(26), enc3(0));
      chk("R4 zero operand", int'(prod_o), 0);
   endtask

   task automatic t_illegal();
      logic [5:0] a;
      logic [5:0] b;
      a = 6'b00_11_01;
      b = enc3(2);
      apply(a, b);
      chk("R8 err set, a side", int'(err_o), 1);
      chk("R8 product with zeroed digit", dec6(prod_o), dec3_zero(a) * 2);
      a = enc3(5);
      b = 6'b11_00_00;
      apply(a, b);
      chk("R8 err set, b side", int'(err_o), 1);
      chk("R8 product b zeroed", dec6(prod_o), 0);
      a = 6'b10_11_10;
      b = 6'b01_11_01;
      apply(a, b);
      chk("R8 err set, both", int'(err_o), 1);
      chk("R8 product both zeroed", dec6(prod_o), dec3_zero(a) * dec3_zero(b));
      apply(enc3(4), enc3(7));
      chk("R8 err clears", int'(err_o), 0);
      chk("R8 product after clear", dec6(prod_o), 28);
   endtask

   task automatic t_latency();
      apply(enc3(3), enc3(3));
      chk("R9 first value", dec6(prod_o), 9);
      a_i = enc3(25);
      b_i = 6'b11_01_01;
      #1;
      chk("R9 holds before edge", dec6(prod_o), 9);
      chk("R9 err holds before edge", int'(err_o), 0);
      @(negedge clk);
      chk("R9 updates after edge", dec6(prod_o), 25 * 4);
      chk("R9 err updates after edge", int'(err_o), 1);
   endtask

   initial begin
      t_reset();
      t_single_digit();
      t_max();
      t_illegal();
      t_latency();
      t_exhaustive();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule